// File: doc/BRIEF.md
# Byte/Word Dual-Read Register File

This block is the general-purpose register storage of a 16-bit datapath. It holds a set of entries, each built from a low byte lane and a high byte lane, and offers two combinational read ports, source and destination, together with one clocked write port. The write port always targets the destination address. This lets an instruction of the form "destination op source" read both operands and write its result back in the same cycle.

A mode input selects word or byte access. Word access reads and writes both lanes as one 16-bit value. Byte access uses the low lane only and leaves the high lane untouched. On a byte read, the low byte is placed in bits 7:0 of each read bus. A placement input then fills bits 15:8 either with zeros or with a copy of the same byte. Operands wider than a word are built by the caller from consecutive word accesses: pairs of entries give eight double-word registers, and groups of four give four quad-word registers.

The write data passes through a four-way source selector. It chooses among the ALU result, a constant or data word from the control unit, data from the bus interface, and the file's own formatted source read bus. The last choice makes register-to-register moves possible. A build-time parameter ties the source read address to entry 0, so that the source port always reads an accumulator.

Top module: `rfbw_regfile`

## Requirements
- R1: While rst_n is low, every entry is cleared to zero. After release, every address reads 0 on both ports.
- R2: src_data shows entry src_addr and dst_data shows entry dst_addr, combinationally and independently. When the two addresses are equal, both buses carry the same value.
- R3: With wr_en high and byte_mode low (word mode), the selected 16-bit write value is stored in entry dst_addr at the rising clock edge. A read of that entry in the same cycle still returns the old value.
- R4: With wr_en high and byte_mode high, only bits 7:0 of entry dst_addr are replaced, by bits 7:0 of the selected write value. Bits 15:8 of the entry keep their previous value.
- R5: With byte_mode high, each read bus carries the entry's bits 7:0 in its bits 7:0. Its bits 15:8 are zero when byte_rep is 0 and a copy of bits 7:0 when byte_rep is 1. With byte_mode low, the full 16-bit entry is returned.
- R6: wr_sel selects the write value: 0 selects alu_data, 1 selects ctl_data, 2 selects biu_data, and 3 selects the current src_data bus, already formatted by R5.
- R7: With wr_en low, no entry changes, whatever the other inputs are.
- R8: With ACC_FIXED set to 1, src_data always shows entry 0, whatever the value of src_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| src_addr | input | 4 | Source read address |
| dst_addr | input | 4 | Destination read address and write address |
| wr_en | input | 1 | Write enable |
| byte_mode | input | 1 | 1 = byte access on the low lane, 0 = word access |
| byte_rep | input | 1 | Byte read placement: 0 = zero upper bits, 1 = replicate the byte |
| wr_sel | input | 2 | Write source: 0 ALU, 1 control, 2 bus interface, 3 source read bus |
| alu_data | input | 16 | Write candidate from the ALU |
| ctl_data | input | 16 | Write candidate from the control unit |
| biu_data | input | 16 | Write candidate from the bus interface |
| src_data | output | 16 | Formatted source read data |
| dst_data | output | 16 | Formatted destination read data |

## Verification
Read results are combinational, so the bench checks both buses in the same cycle in which it sets the addresses and mode, a short delay after the falling edge. A write is due one edge later. The bench drives the write after a falling edge and first checks that the destination bus still shows the old value in that cycle. It then lets one rising edge pass and reads the entry back after the next falling edge. The sweep covers every source and destination pair in word mode, and every address in both byte placements. The hold, loop-back and accumulator-port cases are each compared against a model array that the bench updates from the requirements.

// File: rtl/rfbw_pkg.sv
package rfbw_pkg;
  typedef enum logic [1:0] {
    WSRC_ALU  = 2'd0,
    WSRC_CTL  = 2'd1,
    WSRC_BIU  = 2'd2,
    WSRC_LOOP = 2'd3
  } wsrc_e;
endpackage

// File: rtl/rfbw_lane.sv
// One byte lane of storage: one write port, two combinational read ports.
module rfbw_lane #(
  parameter int LANE_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [LANE_W-1:0] rdata_a,
  output logic [LANE_W-1:0] rdata_b
);
  logic [LANE_W-1:0] mem     [DEPTH];
  logic [LANE_W-1:0] mem_nxt [DEPTH];
  logic [DEPTH*LANE_W-1:0] mem_flat;

  always_comb begin
    mem_nxt = mem;
    mem_nxt[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem <= mem_nxt;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat[g*LANE_W +: LANE_W] = mem[g];
  end

  // R3 / R4: an enabled lane write lands in the addressed entry
  assert_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

  // R7 / R4: a lane that is not enabled keeps every entry
  assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));
endmodule

// File: rtl/rfbw_wsel.sv
// Four-way write-source selector.
module rfbw_wsel
  import rfbw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  wsrc_e             sel,
  input  logic [DATA_W-1:0] alu_in,
  input  logic [DATA_W-1:0] ctl_in,
  input  logic [DATA_W-1:0] biu_in,
  input  logic [DATA_W-1:0] loop_in,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    unique case (sel)
      WSRC_ALU:  wdata = alu_in;
      WSRC_CTL:  wdata = ctl_in;
      WSRC_BIU:  wdata = biu_in;
      WSRC_LOOP: wdata = loop_in;
      default:   wdata = alu_in;
    endcase
  end
endmodule

// File: rtl/rfbw_rdfmt.sv
// Read-bus formatter: word pass-through, or byte with zero-fill / replicate.
module rfbw_rdfmt #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DW    = LANE_W * LANES
) (
  input  logic          byte_mode,
  input  logic          byte_rep,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] fmt
);
  always_comb begin
    if (byte_mode) begin
      fmt[LANE_W-1:0] = raw[LANE_W-1:0];
      for (int l = 1; l < LANES; l++)
        fmt[l*LANE_W +: LANE_W] = byte_rep ? raw[LANE_W-1:0] : '0;
    end else begin
      fmt = raw;
    end
  end
endmodule

// File: rtl/rfbw_regfile.sv
module rfbw_regfile
  import rfbw_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 16,
  parameter bit ACC_FIXED = 1'b0,
  localparam int LANES    = DATA_W / BYTE_W,
  localparam int AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     src_addr,
  input  logic [AW-1:0]     dst_addr,
  input  logic              wr_en,
  input  logic              byte_mode,
  input  logic              byte_rep,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] alu_data,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic [DATA_W-1:0] biu_data,
  output logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] dst_data
);
  logic [AW-1:0]     src_eff;
  logic [DATA_W-1:0] src_raw;
  logic [DATA_W-1:0] dst_raw;
  logic [DATA_W-1:0] wdata;
  logic [LANES-1:0]  lane_we;

  if (ACC_FIXED) begin : g_acc
    assign src_eff = '0;
  end else begin : g_free
    assign src_eff = src_addr;
  end

  rfbw_wsel #(.DATA_W(DATA_W)) u_wsel (
    .sel     (wsrc_e'(wr_sel)),
    .alu_in  (alu_data),
    .ctl_in  (ctl_data),
    .biu_in  (biu_data),
    .loop_in (src_data),
    .wdata   (wdata)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // Lane 0 serves both modes; upper lanes are written in word mode only.
    if (l == 0) begin : g_lo
      assign lane_we[l] = wr_en;
    end else begin : g_hi
      assign lane_we[l] = wr_en & ~byte_mode;
    end

    rfbw_lane #(.LANE_W(BYTE_W), .DEPTH(NUM_REGS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (lane_we[l]),
      .waddr   (dst_addr),
      .wdata   (wdata[l*BYTE_W +: BYTE_W]),
      .raddr_a (src_eff),
      .raddr_b (dst_addr),
      .rdata_a (src_raw[l*BYTE_W +: BYTE_W]),
      .rdata_b (dst_raw[l*BYTE_W +: BYTE_W])
    );
  end

  rfbw_rdfmt #(.LANE_W(BYTE_W), .LANES(LANES)) u_fmt_src (
    .byte_mode (byte_mode),
    .byte_rep  (byte_rep),
    .raw       (src_raw),
    .fmt       (src_data)
  );

  rfbw_rdfmt #(.LANE_W(BYTE_W), .LANES(LANES)) u_fmt_dst (
    .byte_mode (byte_mode),
    .byte_rep  (byte_rep),
    .raw       (dst_raw),
    .fmt       (dst_data)
  );

  // R1: first cycle after reset release reads zero on both ports
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (src_data == '0 && dst_data == '0));

  if (ACC_FIXED) begin : g_chk_acc
    // R8: the source port always reads entry 0
    assert_acc_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_addr == '0) |-> (src_data == dst_data));
  end else begin : g_chk_free
    // R2: equal addresses give equal buses
    assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_addr == dst_addr) |-> (src_data == dst_data));
  end

  // R5: byte placement on the upper bits
  assert_byte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && !byte_rep) |->
      (src_data[DATA_W-1:BYTE_W] == '0 && dst_data[DATA_W-1:BYTE_W] == '0));

  assert_byte_rep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && byte_rep) |->
      (src_data[DATA_W-1:BYTE_W] == {(LANES-1){src_data[BYTE_W-1:0]}}));
endmodule

// File: tb/rfbw_regfile_tb.sv
module rfbw_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_addr, dst_addr;
  logic        wr_en, byte_mode, byte_rep;
  logic [1:0]  wr_sel, acc_sel;
  logic [15:0] alu_data, ctl_data, biu_data;
  logic [15:0] src_data, dst_data, acc_src, acc_dst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] model [16];

  always #10 clk = ~clk;

  // The accumulator copy must not loop back its own (different) source bus.
  assign acc_sel = (wr_sel == 2'd3) ? 2'd0 : wr_sel;

  rfbw_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .dst_addr(dst_addr),
    .wr_en(wr_en), .byte_mode(byte_mode), .byte_rep(byte_rep), .wr_sel(wr_sel),
    .alu_data(alu_data), .ctl_data(ctl_data), .biu_data(biu_data),
    .src_data(src_data), .dst_data(dst_data));

  rfbw_regfile #(.ACC_FIXED(1'b1)) u_dut_acc (
    .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .dst_addr(dst_addr),
    .wr_en(wr_en), .byte_mode(byte_mode), .byte_rep(byte_rep), .wr_sel(acc_sel),
    .alu_data(alu_data), .ctl_data(ctl_data), .biu_data(biu_data),
    .src_data(acc_src), .dst_data(acc_dst));

  function automatic logic [15:0] fmt(input logic [15:0] w, input logic bm, input logic rep);
    return bm ? {(rep ? w[7:0] : 8'h00), w[7:0]} : w;
  endfunction

  task automatic expect16(input string tag, input string what,
                          input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Combinational read of both ports plus the accumulator instance.
  task automatic rd(input logic [3:0] s, input logic [3:0] d,
                    input logic bm, input logic rep, input string tag);
    @(negedge clk);
    wr_en = 1'b0; src_addr = s; dst_addr = d; byte_mode = bm; byte_rep = rep;
    #2;
    expect16(tag, "src", src_data, fmt(model[s], bm, rep));
    expect16(tag, "dst", dst_data, fmt(model[d], bm, rep));
    expect16("R8", "acc src", acc_src, fmt(model[0], bm, rep));
  endtask

  task automatic wr(input logic [3:0] d, input logic [3:0] s, input logic bm,
                    input logic rep, input logic [1:0] sel, input logic [15:0] a,
                    input logic [15:0] c, input logic [15:0] b, input string tag);
    logic [15:0] wv;
    @(negedge clk);
    case (sel)
      2'd0: wv = a;
      2'd1: wv = c;
      2'd2: wv = b;
      default: wv = fmt(model[s], bm, rep);
    endcase
    wr_en = 1'b1; dst_addr = d; src_addr = s; byte_mode = bm; byte_rep = rep;
    wr_sel = sel; ctl_data = c; biu_data = b;
    alu_data = (sel == 2'd3) ? wv : a;
    #2;
    expect16("R3", "old value before edge", dst_data, fmt(model[d], bm, rep));
    @(posedge clk);
    if (bm) model[d][7:0] = wv[7:0];
    else    model[d] = wv;
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    expect16(tag, "after write", dst_data, fmt(model[d], bm, rep));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b1; src_addr = '0; dst_addr = '0; byte_mode = 1'b0;
    byte_rep = 1'b0; wr_sel = 2'd0; alu_data = 16'hFFFF; ctl_data = '0; biu_data = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;

    // R1: every entry reads zero after reset
    for (int i = 0; i < 16; i++) rd(4'(i), 4'(15 - i), 1'b0, 1'b0, "R1");

    // R3 / R6 (sel 0): word writes of every entry from the ALU input
    for (int i = 0; i < 16; i++)
      wr(4'(i), 4'(0), 1'b0, 1'b0, 2'd0, 16'((i + 1) * 16'h1357) ^ 16'h8C00,
         16'h0, 16'h0, "R3");

    // R2: every source/destination pair in word mode
    for (int s = 0; s < 16; s++)
      for (int d = 0; d < 16; d++) rd(4'(s), 4'(d), 1'b0, 1'b0, "R2");

    // R5: byte reads with both placements
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), 4'(i ^ 5), 1'b1, 1'b0, "R5");
      rd(4'(i), 4'(i ^ 9), 1'b1, 1'b1, "R5");
    end

    // R4 / R6 (sel 1): byte writes from control data with junk in the upper bits
    for (int i = 0; i < 16; i++)
      wr(4'(i), 4'(0), 1'b1, 1'(i & 1), 2'd1, 16'hDEAD,
         {8'hEE, 8'(i * 29 + 3)}, 16'hBEEF, "R4");
    for (int i = 0; i < 16; i++) rd(4'(i), 4'(i), 1'b0, 1'b0, "R4");

    // R6 (sel 2): word write from the bus interface
    wr(4'd3, 4'd0, 1'b0, 1'b0, 2'd2, 16'h1111, 16'h2222, 16'hC0DE, "R6");
    // R6 (sel 3): word loop-back of entry 5 into entry 9
    wr(4'd9, 4'd5, 1'b0, 1'b0, 2'd3, 16'h0, 16'h0, 16'h0, "R6");
    // R6 (sel 3): byte loop-back with replication, low byte of 7 into 2
    wr(4'd2, 4'd7, 1'b1, 1'b1, 2'd3, 16'h0, 16'h0, 16'h0, "R6");
    rd(4'd9, 4'd2, 1'b0, 1'b0, "R6");
    rd(4'd3, 4'd5, 1'b0, 1'b0, "R6");

    // R7: inputs toggling with write enable low change nothing
    @(negedge clk);
    wr_en = 1'b0; byte_mode = 1'b0; wr_sel = 2'd2;
    for (int i = 0; i < 16; i++) begin
      dst_addr = 4'(i); alu_data = 16'(i * 771); ctl_data = ~alu_data; biu_data = 16'hA5A5;
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) rd(4'(i), 4'(15 - i), 1'b0, 1'b0, "R7");

    // R8: source address sweep on the accumulator instance
    for (int i = 0; i < 16; i++) rd(4'(i), 4'd0, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule